// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds the 64-bit register that places the memory-mapped PCIe configuration window of a host bridge in the system address map. Software writes the register through a port with one enable per byte. The block turns the stored value into a window enable, a base address and a window length. From those it derives the lower bound of the 32-bit PCI memory hole, which starts right after the window when the window is on and at the reset base when it is off.

A second port takes 32-bit system addresses. For each request the block answers one cycle later with a hit flag. On a hit it also returns the bus, device, function and register offset that the address selects inside the window. The window can be 256 MiB, 128 MiB or 64 MiB. The compare mask and the width of the bus field follow the selected length.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the register reads 0x0000_0000_B000_0000. The window is off, the length decodes to 256 MiB, the error flag is low and the hole lower bound is 0xB000_0000.
- R2: A write changes exactly the register bytes whose byte enable is set. Byte k covers bits 8k+7:8k. With no write, the register holds its value.
- R3: Bits 2:1 of the register select the window length: 00 gives 256 MiB, 01 gives 128 MiB, 10 gives 64 MiB.
- R4: The decoded base is the register masked to bits 38:28. Bit 27 is added to the mask for 128 MiB, and bits 27 and 26 are added for 64 MiB.
- R5: A write whose merged value would carry length code 11 leaves the register unchanged and sets the error flag. The flag stays set until reset.
- R6: Bit 0 of the register enables the window. While it is 0, no address hits.
- R7: A lookup request presented in one cycle is answered with a valid strobe in the next cycle. The answer is a hit exactly when the enable is set and the zero-extended address, masked by the window mask, equals the decoded base.
- R8: On a hit, the offset inside the window is split into bus = offset[27:20], device = offset[19:15], function = offset[14:12] and register = offset[11:0]. Offset bits at or above the window size read as zero, so for example bus[7:6] is 0 for 64 MiB. On a miss all fields are zero.
- R9: The hole lower bound equals base plus length while the window is on, and 0xB000_0000 while it is off. This also holds when the sum carries past 32 bits.
- R10: The hole upper bound is constant at 0xFEBF_FFFF.
- R11: A lookup issued after a register write completes uses the new decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 8 | Byte enables of the write |
| wr_data | input | 64 | Write data |
| cfg_q | output | 64 | Current register value |
| cfg_err | output | 1 | Sticky flag for a rejected length code |
| win_en | output | 1 | Window enable |
| win_base | output | 64 | Decoded window base |
| win_len | output | 32 | Window length in bytes |
| hole_lo | output | 64 | Lower bound of the 32-bit PCI hole |
| hole_hi | output | 32 | Upper bound of the 32-bit PCI hole |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | System address to look up |
| lk_vld | output | 1 | Lookup answer valid |
| lk_hit | output | 1 | Address falls inside the window |
| lk_bus | output | 8 | Bus number |
| lk_dev | output | 5 | Device number |
| lk_fn | output | 3 | Function number |
| lk_off | output | 12 | Register offset |

## Verification
The bench shrinks the window from 256 MiB down to 64 MiB around a base that has bits 27:26 set. A design with the wrong mask would then keep stray base bits, or would hit addresses just past the smaller window. The bench probes both edges of each window size and an address whose bus field would show bits 7:6 if truncation were missing. A reserved length write follows a valid one: a design that stores the code or drops the error flag after a later good write shows a changed register or a cleared flag. Writes to single bytes, including the upper dword, catch byte enables that are ignored or shifted. A window ending at 4 GiB and a disabled window catch a hole bound that wraps or that ignores the enable.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  typedef enum logic [1:0] {
    WLEN_256 = 2'b00,
    WLEN_128 = 2'b01,
    WLEN_64  = 2'b10,
    WLEN_RSV = 2'b11
  } wlen_e;

  typedef struct packed {
    logic        hit;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
  } cfg_tgt_t;

endpackage

// File: rtl/cfgwin_reg.sv
module cfgwin_reg
  import cfgwin_pkg::*;
#(
  parameter int          REG_W   = 64,
  parameter logic [63:0] RST_VAL = 64'h0000_0000_B000_0000,
  parameter int          LEN_LSB = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   reg_q,
  output logic               err_q
);
  localparam int NBYTE = REG_W / 8;

  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] reg_d;
  logic             err_d;
  logic             bad_code;

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : reg_q[8*b +: 8];
  end

  assign bad_code = (merged[LEN_LSB +: 2] == WLEN_RSV);

  always_comb begin
    reg_d = reg_q;
    err_d = err_q;
    if (wr_en && (|wr_be)) begin
      if (bad_code) err_d = 1'b1;
      else          reg_d = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= RST_VAL[REG_W-1:0];
      err_q <= 1'b0;
    end else begin
      reg_q <= reg_d;
      err_q <= err_d;
    end
  end

  // R5
  no_rsv_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_q[LEN_LSB +: 2] != WLEN_RSV);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_q));

endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int          REG_W    = 64,
  parameter int          ADDR_HI  = 38,
  parameter int          WIN_LSB  = 26,
  parameter int          LEN_LSB  = 1,
  parameter logic [63:0] DEF_BASE = 64'h0000_0000_B000_0000
) (
  input  logic [REG_W-1:0] reg_i,
  output logic             en_o,
  output wlen_e            code_o,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] base_o,
  output logic [31:0]      len_o,
  output logic [REG_W-1:0] hole_lo_o
);
  localparam int          NEXTRA  = 2;
  localparam int          FIX_LSB = WIN_LSB + NEXTRA;
  localparam logic [31:0] MAX_LEN = 32'd1 << FIX_LSB;

  assign en_o   = reg_i[0];
  assign code_o = wlen_e'(reg_i[LEN_LSB +: 2]);

  for (genvar i = 0; i < REG_W; i++) begin : g_mask
    if (i > ADDR_HI || i < WIN_LSB) begin : g_zero
      assign mask_o[i] = 1'b0;
    end else if (i >= FIX_LSB) begin : g_fix
      assign mask_o[i] = 1'b1;
    end else begin : g_var
      // bit FIX_LSB-1-k joins the mask once the code exceeds k
      assign mask_o[i] = (32'(code_o) > 32'(FIX_LSB - 1 - i));
    end
  end

  assign base_o    = reg_i & mask_o;
  assign len_o     = MAX_LEN >> code_o;
  assign hole_lo_o = en_o ? (base_o + REG_W'(len_o)) : DEF_BASE[REG_W-1:0];

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match
  import cfgwin_pkg::*;
#(
  parameter int REG_W   = 64,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               en_i,
  input  logic [REG_W-1:0]   mask_i,
  input  logic [REG_W-1:0]   base_i,
  output logic               vld_o,
  output cfg_tgt_t           tgt_o
);
  logic [REG_W-1:0] addr_x;
  logic [REG_W-1:0] offs;
  cfg_tgt_t         tgt_d;
  logic             vld_d;

  assign addr_x = REG_W'(addr_i);
  assign offs   = addr_x & ~mask_i;

  always_comb begin
    tgt_d     = '0;
    tgt_d.hit = en_i && ((addr_x & mask_i) == base_i);
    if (tgt_d.hit) begin
      tgt_d.bus = offs[27:20];
      tgt_d.dev = offs[19:15];
      tgt_d.fn  = offs[14:12];
      tgt_d.off = offs[11:0];
    end
    vld_d = req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      tgt_o <= '0;
    end else begin
      vld_o <= vld_d;
      if (req_i) tgt_o <= tgt_d;
    end
  end

  // R7
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(req_i));
  // R6
  no_hit_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && tgt_o.hit) |-> $past(en_i));

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
  import cfgwin_pkg::*;
#(
  parameter int          REG_W    = 64,
  parameter int          ADDR_W   = 32,
  parameter int          ADDR_HI  = 38,
  parameter int          WIN_LSB  = 26,
  parameter int          LEN_LSB  = 1,
  parameter logic [63:0] DEF_BASE = 64'h0000_0000_B000_0000,
  parameter logic [31:0] HOLE_TOP = 32'hFEC0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W/8-1:0] wr_be,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   cfg_q,
  output logic               cfg_err,
  output logic               win_en,
  output logic [REG_W-1:0]   win_base,
  output logic [31:0]        win_len,
  output logic [REG_W-1:0]   hole_lo,
  output logic [31:0]        hole_hi,
  input  logic               lk_req,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               lk_vld,
  output logic               lk_hit,
  output logic [7:0]         lk_bus,
  output logic [4:0]         lk_dev,
  output logic [2:0]         lk_fn,
  output logic [11:0]        lk_off
);
  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  wlen_e            code;
  logic [REG_W-1:0] mask;
  cfg_tgt_t         tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  cfgwin_reg #(.REG_W(REG_W), .RST_VAL(DEF_BASE), .LEN_LSB(LEN_LSB)) u_reg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .reg_q(cfg_q), .err_q(cfg_err));

  cfgwin_decode #(.REG_W(REG_W), .ADDR_HI(ADDR_HI), .WIN_LSB(WIN_LSB),
                  .LEN_LSB(LEN_LSB), .DEF_BASE(DEF_BASE)) u_dec (
    .reg_i(cfg_q), .en_o(win_en), .code_o(code), .mask_o(mask),
    .base_o(win_base), .len_o(win_len), .hole_lo_o(hole_lo));

  cfgwin_match #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst_n(rst_s_n), .req_i(lk_req), .addr_i(lk_addr),
    .en_i(win_en), .mask_i(mask), .base_i(win_base),
    .vld_o(lk_vld), .tgt_o(tgt));

  assign hole_hi = HOLE_TOP - 32'd1;
  assign lk_hit  = tgt.hit;
  assign lk_bus  = tgt.bus;
  assign lk_dev  = tgt.dev;
  assign lk_fn   = tgt.fn;
  assign lk_off  = tgt.off;

  // R8
  bus_trunc_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lk_vld && lk_hit && $past(code) == WLEN_64) |-> (lk_bus[7:6] == 2'b00));
  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lk_vld && !lk_hit) |-> ({lk_bus, lk_dev, lk_fn, lk_off} == '0));

endmodule

// File: tb/sim_cfgwin_decoder.sv
module sim_cfgwin_decoder;
  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [63:0] cfg_q, win_base, hole_lo;
  logic        cfg_err, win_en, lk_vld, lk_hit;
  logic [31:0] win_len, hole_hi;
  logic [7:0]  lk_bus;
  logic [4:0]  lk_dev;
  logic [2:0]  lk_fn;
  logic [11:0] lk_off;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  logic  done = 1'b0;
  exp_t  sb[$];
  logic [63:0] m_reg;
  logic        m_err;

  always #5 clk = ~clk;

  cfgwin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .cfg_q(cfg_q), .cfg_err(cfg_err), .win_en(win_en), .win_base(win_base),
    .win_len(win_len), .hole_lo(hole_lo), .hole_hi(hole_hi),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_vld(lk_vld), .lk_hit(lk_hit),
    .lk_bus(lk_bus), .lk_dev(lk_dev), .lk_fn(lk_fn), .lk_off(lk_off));

  function automatic logic [31:0] m_len();
    return 32'h1000_0000 >> m_reg[2:1];
  endfunction
  function automatic logic [63:0] m_base();
    return {25'b0, m_reg[38:0]} & ~(64'(m_len()) - 64'd1);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " R2 reg"}, cfg_q, m_reg);
    chk({tag, " R5 err"}, 64'(cfg_err), 64'(m_err));
    chk({tag, " R6 en"}, 64'(win_en), 64'(m_reg[0]));
    chk({tag, " R3 len"}, 64'(win_len), 64'(m_len()));
    chk({tag, " R4 base"}, win_base, m_base());
    chk({tag, " R9 hole_lo"}, hole_lo,
        m_reg[0] ? m_base() + 64'(m_len()) : 64'hB000_0000);
    chk({tag, " R10 hole_hi"}, 64'(hole_hi), 64'hFEBF_FFFF);
  endtask

  task automatic wr(input logic [7:0] be, input logic [63:0] d);
    logic [63:0] mg;
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
    for (int b = 0; b < 8; b++)
      mg[8*b +: 8] = be[b] ? d[8*b +: 8] : m_reg[8*b +: 8];
    if (mg[2:1] == 2'b11) m_err = 1'b1;
    else                  m_reg = mg;
    chk_state("after write");
  endtask

  task automatic look(input logic [31:0] a);
    exp_t        e;
    logic [31:0] o;
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    o = a & (m_len() - 32'd1);
    e = '0;
    e.addr = a;
    e.hit = m_reg[0] && (({32'b0, a} & ~(64'(m_len()) - 64'd1)) == m_base());
    if (e.hit) begin
      e.bus = o[27:20]; e.dev = o[19:15]; e.fn = o[14:12]; e.off = o[11:0];
    end
    sb.push_back(e);
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && lk_vld) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R7: unexpected answer, actual vld 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk($sformatf("R7 hit @%h", e.addr), 64'(lk_hit), 64'(e.hit));
        chk($sformatf("R8 fields @%h", e.addr),
            64'({lk_bus, lk_dev, lk_fn, lk_off}),
            64'({e.bus, e.dev, e.fn, e.off}));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_reg = 64'h0000_0000_B000_0000;
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_state("R1 reset");
    look(32'hB000_0000);            // R6 disabled window misses
    look(32'hB123_4567);
    // R3 256 MiB enabled
    wr(8'hFF, 64'h0000_0000_B000_0001);
    look(32'hB012_3456);            // R8 split
    look(32'hBFFF_FFFF);
    look(32'hAFFF_FFFF);
    look(32'hC000_0000);
    // R2 byte0 only, 128 MiB; R11 new decode applies
    wr(8'h01, 64'hFFFF_FFFF_FFFF_FF03);
    look(32'hB7F0_8ABC);
    look(32'hB800_0000);
    // 64 MiB
    wr(8'h01, 64'h05);
    look(32'hB3FF_FFFF);            // R8 bus[7:6] truncated
    look(32'hB400_0000);
    // R4 base with bits 27:26 set, byte 3 only
    wr(8'h08, 64'hEC00_0000);
    look(32'hEC10_0000);
    look(32'hE800_0000);
    wr(8'h01, 64'h03);              // 128 MiB: bit 26 drops out
    look(32'hE800_0000);
    look(32'hEFFF_FFFF);
    wr(8'h01, 64'h01);              // 256 MiB: base E000_0000
    look(32'hE000_0000);
    // R5 reserved code
    wr(8'h01, 64'h07);
    look(32'hE123_4000);
    wr(8'h01, 64'h05);              // valid write, error stays set
    // R9 carry past 4 GiB
    wr(8'h09, 64'hF000_0001);
    look(32'hFFFF_FFFF);
    // R2 upper dword: window above 4 GiB
    wr(8'h10, 64'h0000_0001_0000_0000);
    look(32'hF000_0000);
    wr(8'h10, 64'h0);
    // R9 disabled fallback
    wr(8'h01, 64'h00);
    look(32'hF000_0000);
    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule